// File: doc/BRIEF.md
# Memory Operand Effective Address Unit

This block turns the already decoded addressing bytes of an x86 memory operand into a 64-bit effective address. Its inputs are the ModRM byte, the SIB byte, a flag that says whether a SIB byte is present, the low nibble of the REX prefix, a flag for 64-bit mode and a 32-bit displacement. It names up to two general registers on two combinational read ports into an external 16 x 64-bit register array. One port carries the base or rm register and the other carries the index register. It then adds the selected terms together.

A request is accepted by a single-cycle `start_i` pulse. The controller has two states. `ST_IDLE` waits for a request, and the transition `IDLE->DONE` happens on an accepted start. `ST_DONE` presents the registered result with `done_o` high for exactly one cycle, and its only transition is `DONE->IDLE`. A start in `ST_DONE` is dropped. Outside 64-bit mode, any register number of 8 or above that is actually used in the sum is reported as a decode error, and the address is then forced to all ones.

Top module: `ea_calc`

## Requirements
- R1: While and after reset, `done_o`, `err_o` and `addr_o` are all zero until the first accepted request.
- R2: A start seen in `ST_IDLE` produces `done_o` high in the next cycle only, together with the result of that request.
- R3: A start that arrives while `done_o` is high is ignored: `done_o` is low in the following cycle and `addr_o`/`err_o` keep their values.
- R4: With ModRM[7:6]=3 the address is the register numbered {REX bit0, ModRM[2:0]}; no displacement and no SIB term are added.
- R5: With ModRM[7:6]!=3 and no SIB byte, the address is register {REX bit0, ModRM[2:0]} plus the displacement.
- R6: With a SIB byte and ModRM[7:6]!=3, the address is base + (index << SIB[7:6]) + displacement, where the base register is {REX bit0, SIB[2:0]} and the index register is {REX bit1, SIB[5:3]}.
- R7: An index register number of exactly 4 contributes zero; index 12 (REX bit1 set, SIB[5:3]=4) is a real register.
- R8: With ModRM[7:6]=0 and a raw SIB[2:0] of 5, the base term is zero whatever REX bit0 is; with ModRM[7:6] of 1 or 2, the base is register {REX bit0, 5}.
- R9: With `long_mode_i` low, any used register number of 8 or above sets `err_o` and makes `addr_o` all ones. With `long_mode_i` high, `err_o` is never set.
- R10: The displacement is sign-extended from 32 bits, and the whole sum wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse; inputs are sampled with it |
| modrm_i | input | 8 | ModRM byte |
| sib_i | input | 8 | SIB byte |
| sib_present_i | input | 1 | A SIB byte follows ModRM |
| rex_i | input | 4 | REX low nibble (bit0 extends base/rm, bit1 extends index) |
| long_mode_i | input | 1 | 64-bit mode; registers 8-15 are legal |
| disp_i | input | 32 | Signed displacement |
| rd_a_idx_o | output | 4 | Register number on the base/rm read port |
| rd_a_data_i | input | 64 | Data returned for `rd_a_idx_o` |
| rd_b_idx_o | output | 4 | Register number on the index read port |
| rd_b_data_i | input | 64 | Data returned for `rd_b_idx_o` |
| done_o | output | 1 | Result valid pulse |
| err_o | output | 1 | Illegal register number |
| addr_o | output | 64 | Effective address |

## Verification
Two pairs of functions can meet in one cycle. First, result delivery can meet a new request. The bench holds `start_i` high through the `ST_DONE` cycle with different operands, and it passes only if `done_o` drops afterwards and the delivered address is unchanged. Second, the absent-base and absent-index cases can meet inside one address. The sweep covers every SIB byte at every mod value under all four REX combinations, so mod 0 with base field 5 and index 4 occurs and must give the displacement alone. Each result is compared with a value the bench computes arithmetically from its own register contents.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int XLEN    = 64;
    localparam int DISP_W  = 32;
    localparam int RIDX_W  = 4;
    localparam int FIELD_W = RIDX_W - 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } agu_state_e;
endpackage

// File: rtl/agu_regsel.sv
module agu_regsel
    import agu_pkg::*;
(
    input  logic [7:0]        modrm,
    input  logic [7:0]        sib,
    input  logic              sib_present,
    input  logic              ext_base,
    input  logic              ext_index,
    input  logic              long_mode,
    output logic [RIDX_W-1:0] a_idx,
    output logic              a_use,
    output logic [RIDX_W-1:0] b_idx,
    output logic              b_use,
    output logic [1:0]        scale,
    output logic              add_disp,
    output logic              bad_reg
);
    localparam logic [FIELD_W-1:0] NO_BASE_CODE  = FIELD_W'(5);
    localparam logic [RIDX_W-1:0]  NO_INDEX_CODE = RIDX_W'(4);

    logic [1:0]         mode_f;
    logic               mem_form;
    logic               with_sib;
    logic [FIELD_W-1:0] base_f;

    always_comb begin
        mode_f   = modrm[7:6];
        mem_form = (mode_f != 2'b11);
        with_sib = mem_form && sib_present;
        base_f   = with_sib ? sib[2:0] : modrm[2:0];
        a_idx    = {ext_base, base_f};
        // the absent-base test looks at the raw field, before extension
        a_use    = !(with_sib && mode_f == 2'b00 && sib[2:0] == NO_BASE_CODE);
        // the absent-index test looks at the extended number
        b_idx    = {ext_index, sib[5:3]};
        b_use    = with_sib && (b_idx != NO_INDEX_CODE);
        scale    = with_sib ? sib[7:6] : 2'b00;
        add_disp = mem_form;
        bad_reg  = !long_mode && ((a_use && a_idx[RIDX_W-1]) ||
                                  (b_use && b_idx[RIDX_W-1]));
    end

    always_comb begin
        if (modrm[7:6] == 2'b11) begin
            a_r4_reg_only: assert (a_use && !b_use && !add_disp);
        end
    end
endmodule

// File: rtl/agu_sum.sv
module agu_sum
    import agu_pkg::*;
(
    input  logic [XLEN-1:0]   a_data,
    input  logic              a_use,
    input  logic [XLEN-1:0]   b_data,
    input  logic              b_use,
    input  logic [1:0]        scale,
    input  logic              add_disp,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   sum
);
    logic [XLEN-1:0] base_t, index_t, disp_t;

    always_comb begin
        base_t  = a_use ? a_data : '0;
        index_t = b_use ? (b_data << scale) : '0;
        disp_t  = add_disp ? {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp} : '0;
        sum     = base_t + index_t + disp_t;
    end
endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
    import agu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic done
);
    agu_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = start;
                if (start) state_d = ST_DONE;
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    a_r2_start_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> done);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import agu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        modrm_i,
    input  logic [7:0]        sib_i,
    input  logic              sib_present_i,
    input  logic [3:0]        rex_i,
    input  logic              long_mode_i,
    input  logic [31:0]       disp_i,
    output logic [3:0]        rd_a_idx_o,
    input  logic [63:0]       rd_a_data_i,
    output logic [3:0]        rd_b_idx_o,
    input  logic [63:0]       rd_b_data_i,
    output logic              done_o,
    output logic              err_o,
    output logic [63:0]       addr_o
);
    logic            a_use, b_use, add_disp, bad_reg, accept;
    logic [1:0]      scale;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] addr_q;
    logic            err_q;

    agu_regsel u_sel (
        .modrm       (modrm_i),
        .sib         (sib_i),
        .sib_present (sib_present_i),
        .ext_base    (rex_i[0]),
        .ext_index   (rex_i[1]),
        .long_mode   (long_mode_i),
        .a_idx       (rd_a_idx_o),
        .a_use       (a_use),
        .b_idx       (rd_b_idx_o),
        .b_use       (b_use),
        .scale       (scale),
        .add_disp    (add_disp),
        .bad_reg     (bad_reg)
    );

    agu_sum u_sum (
        .a_data   (rd_a_data_i),
        .a_use    (a_use),
        .b_data   (rd_b_data_i),
        .b_use    (b_use),
        .scale    (scale),
        .add_disp (add_disp),
        .disp     (disp_i),
        .sum      (sum)
    );

    agu_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_i),
        .accept (accept),
        .done   (done_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            err_q  <= 1'b0;
        end else if (accept) begin
            addr_q <= bad_reg ? '1 : sum;
            err_q  <= bad_reg;
        end
    end

    assign addr_o = addr_q;
    assign err_o  = err_q;

    a_r9_err_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (&addr_o));
    a_r9_long_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && long_mode_i) |=> !err_o);
    a_r4_mod3_value: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && long_mode_i && modrm_i[7:6] == 2'b11) |=> (addr_o == $past(rd_a_data_i)));
    a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(addr_o));
endmodule

// File: tb/ea_calc_tb.sv
`timescale 1ns/1ps
module ea_calc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  modrm_i = '0, sib_i = '0;
    logic        sib_present_i = 1'b0;
    logic [3:0]  rex_i = '0;
    logic        long_mode_i = 1'b0;
    logic [31:0] disp_i = '0;
    logic [3:0]  rd_a_idx_o, rd_b_idx_o;
    logic [63:0] rd_a_data_i, rd_b_data_i;
    logic        done_o, err_o;
    logic [63:0] addr_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ea_calc dut_i (.*);

    function automatic logic [63:0] regval(input logic [3:0] n);
        return 64'h9E37_79B9_7F4A_7C15 * (64'(n) + 64'd1);
    endfunction

    always_comb rd_a_data_i = regval(rd_a_idx_o);
    always_comb rd_b_data_i = regval(rd_b_idx_o);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected result built from the requirement text
    task automatic model(input logic lm, input logic [7:0] m, input logic [7:0] s,
                         input logic sp, input logic [3:0] rx, input logic [31:0] d,
                         output logic e, output logic [63:0] a, output string tag);
        int base_n, idx_n;
        logic has_base, has_idx;
        logic [63:0] total;
        has_idx = 0; idx_n = 0;
        if (m[7:6] == 2'd3) begin
            base_n = {rx[0], m[2:0]}; has_base = 1; tag = "R4";
            total = regval(4'(base_n));
        end else if (!sp) begin
            base_n = {rx[0], m[2:0]}; has_base = 1; tag = "R5";
            total = regval(4'(base_n)) + {{32{d[31]}}, d};
        end else begin
            base_n = {rx[0], s[2:0]};
            has_base = !(m[7:6] == 2'd0 && s[2:0] == 3'd5);
            idx_n = {rx[1], s[5:3]};
            has_idx = (idx_n != 4);
            tag = !has_base ? "R8" : (!has_idx ? "R7" : "R6");
            total = {{32{d[31]}}, d};
            if (has_base) total = total + regval(4'(base_n));
            if (has_idx)  total = total + regval(4'(idx_n)) * (64'd1 << s[7:6]);
        end
        e = !lm && ((has_base && base_n >= 8) || (has_idx && idx_n >= 8));
        if (e) begin a = '1; tag = "R9"; end
        else a = total;
    endtask

    task automatic run(input logic lm, input logic [7:0] m, input logic [7:0] s,
                       input logic sp, input logic [3:0] rx, input logic [31:0] d);
        logic e; logic [63:0] a; string tag;
        model(lm, m, s, sp, rx, d, e, a, tag);
        @(negedge clk);
        long_mode_i = lm; modrm_i = m; sib_i = s; sib_present_i = sp; rex_i = rx; disp_i = d;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({"R2 done ", tag}, 64'(done_o), 64'd1);
        check({tag, " err"}, 64'(err_o), 64'(e));
        check({tag, " addr"}, addr_o, a);
    endtask

    initial begin
        logic [31:0] dl [5] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFC, 32'h10};
        logic [63:0] held;
        int k = 0;
        repeat (3) @(negedge clk);
        check("R1 done", 64'(done_o), 0);
        check("R1 err", 64'(err_o), 0);
        check("R1 addr", addr_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle done", 64'(done_o), 0);
        check("R1 idle addr", addr_o, 0);

        for (int lm = 0; lm < 2; lm++)
            for (int md = 0; md < 4; md++)
                for (int bx = 0; bx < 4; bx++)
                    for (int sp = 0; sp < 2; sp++)
                        for (int v = 0; v < (sp ? 256 : 8); v++) begin
                            run(lm[0], {md[1:0], 3'b010, sp ? 3'b100 : v[2:0]},
                                sp ? v[7:0] : (v[7:0] ^ 8'h5A), sp[0], {2'b00, bx[1:0]},
                                dl[k % 5]);
                            k++;
                        end

        // R10: wrap and negative displacement
        run(1'b1, 8'b10_000_000, 8'h00, 1'b0, 4'h0, 32'h8000_0000);
        check("R10 wrap", addr_o, regval(4'd0) - 64'h8000_0000);
        run(1'b1, 8'b00_000_100, 8'b11_111_111, 1'b1, 4'h3, 32'hFFFF_FFFF);
        check("R10 mod2^64", addr_o, regval(4'd15) + regval(4'd15) * 8 - 1);
        // R8 and R7 together: displacement alone
        run(1'b1, 8'b00_000_100, 8'b00_100_101, 1'b1, 4'h1, 32'h1234);
        check("R8 R7 disp only", addr_o, 64'h1234);

        // R3: start held through the done cycle
        @(negedge clk);
        long_mode_i = 1; modrm_i = 8'hC3; sib_present_i = 0; rex_i = 0; disp_i = 0;
        start_i = 1'b1;
        @(negedge clk);
        check("R3 first done", 64'(done_o), 1);
        held = addr_o;
        check("R3 first addr", held, regval(4'd3));
        modrm_i = 8'hC6;
        @(negedge clk);
        start_i = 1'b0;
        check("R3 ignored done", 64'(done_o), 0);
        check("R3 ignored addr", addr_o, held);
        @(negedge clk);
        check("R2 no stray done", 64'(done_o), 0);

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule